// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is one output cell of a programmable logic block. It receives an already-summed product-term value, a second term that can be folded in through an exclusive-OR, and a set of configuration bits. It produces the value for a pin and the same value as internal feedback. The cell can pass its logic straight through, hold it in a level-sensitive latch, or hold it in an edge-triggered register. The register can behave as a D, T, JK or SR flip-flop. An output inversion is applied after the storage element.

Each cell has its own mode bit that selects one of two schemes for clocking and initialization. In the shared scheme, the cell uses one of the block clocks and the two block-wide initialization terms, and a swap bit decides which of those terms presets and which resets. In the individual scheme, the cell may also use its own product-term clock on either edge, and a single local term that is configured as either a preset or a reset.

The cell runs on one system clock. Macrocell clocks and initialization terms are sampled as levels. A macrocell clock edge is a change in the selected clock source between two system clock samples. A state change becomes visible on the outputs just after the system clock edge at which its cause was sampled.

Top module: `mcell_top`

## Requirements
- R1: While `rst_n` is sampled low, the stored state clears to 0. In latched or registered mode `pin_out` then equals `inv_out`.
- R2: `out_mode` encodes 0 as combinational, 1 as latched, and 2 or 3 as registered. In combinational mode `pin_out` = (`sop_in` XOR (`xor_en` AND `xor_in`)) XOR `inv_out`, with no clock involved.
- R3: `inv_out` inverts after the storage element. `fb_out` always equals `pin_out`, in every mode.
- R4: `ff_type` encodes 0=D, 1=T, 2=JK, 3=SR. As a D type, a rising edge of the selected clock loads f = `sop_in` XOR (`xor_en` AND `xor_in`).
- R5: As a T type, a rising clock edge inverts the state when f is 1 and holds it when f is 0.
- R6: As a JK type, J is `sop_in` and K is `xor_in`. 10 sets, 01 clears, 00 holds and 11 toggles.
- R7: As an SR type, S is `sop_in` and R is `xor_in`. 10 sets, 01 clears, and both 00 and 11 hold.
- R8: In latched mode the state follows f while the selected clock source is high, and holds while it is low.
- R9: In the shared scheme (`async_mode`=0), `clk_sel` bits [1:0] pick `blk_clk`, and the top bit is ignored. The state changes only on rising edges of the picked clock.
- R10: In the individual scheme, `clk_sel` values of 4 and above pick `ptc_in`. The active edge is rising when `ptc_fall`=0 and falling when `ptc_fall`=1.
- R11: In the shared scheme with `init_swap`=0, `blk_init_a` presets and `blk_init_b` resets. With `init_swap`=1 the roles are exchanged. `loc_init` has no effect.
- R12: In the individual scheme, `loc_init` presets when `loc_init_is_preset`=1 and resets otherwise. `blk_init_a` and `blk_init_b` have no effect.
- R13: Preset and reset override any clock or latch update. When both are active, reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| sop_in | input | 1 | Summed product-term logic value |
| xor_in | input | 1 | Second term: XOR operand, or K/R input |
| xor_en | input | 1 | Fold `xor_in` into f through the XOR gate |
| out_mode | input | 2 | 0 combinational, 1 latched, 2/3 registered |
| ff_type | input | 2 | 0 D, 1 T, 2 JK, 3 SR |
| inv_out | input | 1 | Invert the output after storage |
| async_mode | input | 1 | 0 shared scheme, 1 individual scheme |
| blk_clk | input | NUM_BLK_CLK | Block clocks |
| clk_sel | input | $clog2(NUM_BLK_CLK)+1 | Clock source select |
| ptc_in | input | 1 | Product-term clock |
| ptc_fall | input | 1 | Use the falling edge of `ptc_in` |
| blk_init_a | input | 1 | Block initialization term A |
| blk_init_b | input | 1 | Block initialization term B |
| init_swap | input | 1 | Swap the roles of the block terms |
| loc_init | input | 1 | Local initialization term |
| loc_init_is_preset | input | 1 | Local term presets (1) or resets (0) |
| pin_out | output | 1 | Value towards the pin |
| fb_out | output | 1 | Internal feedback value |

## Verification
The bench drives both JK 11 and SR 11 inputs. A cell that treated these the same way would show either a missing toggle or a spurious change. It presents preset and reset together and a reset during a clock edge, which catches a wrong priority order or an initialization that yields to the clock. It moves `ptc_fall` and `init_swap`, and applies block and local terms in the scheme where they must be ignored. A routing fault there would give an inverted edge, preset and reset exchanged, or a state change from a dead term. It also runs the latch closed, sends falling edges of a rising-edge clock, and sends edges on a clock that is not selected. A cell that leaked updates through any of these would change its output.

// File: rtl/mcell_pkg.sv
// Package: shared encodings and the flip-flop next-state function of the macrocell.
// Assumes callers pass the current state and two data inputs already routed.
package mcell_pkg;

    typedef enum logic [1:0] {
        OM_COMB  = 2'd0,
        OM_LATCH = 2'd1,
        OM_REG   = 2'd2,
        OM_REG2  = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        FT_D  = 2'd0,
        FT_T  = 2'd1,
        FT_JK = 2'd2,
        FT_SR = 2'd3
    } ff_type_e;

    // Next state of the emulated flip-flop; a is D/T/J/S, b is K/R.
    function automatic logic ff_next(ff_type_e t, logic q, logic a, logic b);
        logic n;
        case (t)
            FT_D:    n = a;
            FT_T:    n = q ^ a;
            FT_JK:   n = (a & ~q) | (~b & q);
            default: n = (a & ~b) ? 1'b1 : ((~a & b) ? 1'b0 : q);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mcell_clk_sel.sv
// Module: picks the macrocell clock source and derives its level and edge.
// The level drives a latch gate; the edge is a one-cycle pulse on clk.
// Assumes NUM_BLK_CLK is a power of two; select codes at or above it
// choose the product-term clock, but only in the individual scheme.
module mcell_clk_sel #(
    parameter int NUM_BLK_CLK = 4,
    localparam int IDX_W = $clog2(NUM_BLK_CLK),
    localparam int SEL_W = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BLK_CLK-1:0] blk_clk,
    input  logic [SEL_W-1:0]       clk_sel,
    input  logic                   async_mode,
    input  logic                   ptc_in,
    input  logic                   ptc_fall,
    output logic                   gate,
    output logic                   fire
);
    localparam logic [SEL_W-1:0] PTC_CODE = SEL_W'(NUM_BLK_CLK);

    logic src;
    logic src_q;

    // Select the source; a falling product-term edge is turned into a rising one.
    always_comb begin
        if (async_mode && (clk_sel >= PTC_CODE))
            src = ptc_in ^ ptc_fall;
        else
            src = blk_clk[clk_sel[IDX_W-1:0]];
    end

    // Remember the previous source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign gate = src;
    assign fire = src & ~src_q;

    // R9: an edge pulse never lasts two system cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/mcell_init.sv
// Module: routes the initialization terms to preset and reset for one cell.
// Shared scheme: two block terms with a role swap. Individual scheme: one local term.
module mcell_init (
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic blk_init_a,
    input  logic blk_init_b,
    input  logic init_swap,
    input  logic loc_init,
    input  logic loc_init_is_preset,
    output logic set,
    output logic clr
);
    // Choose the preset and reset sources according to the scheme.
    always_comb begin
        if (async_mode) begin
            set = loc_init & loc_init_is_preset;
            clr = loc_init & ~loc_init_is_preset;
        end else begin
            set = init_swap ? blk_init_b : blk_init_a;
            clr = init_swap ? blk_init_a : blk_init_b;
        end
    end

    // R12: the single local term can never preset and reset at once
    a_r12_one_function: assert property (@(posedge clk) disable iff (!rst_n)
        async_mode |-> !(set && clr));

endmodule

// File: rtl/mcell_store.sv
// Module: the storage element. It acts as a latch or an emulated D/T/JK/SR register.
// Reset beats preset; both override any clocked or latch update.
// In combinational mode the state only holds, though initialization still applies.
module mcell_store
    import mcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  ff_type_e  ftype,
    input  logic      d_a,
    input  logic      d_b,
    input  logic      gate,
    input  logic      fire,
    input  logic      set,
    input  logic      clr,
    output logic      q
);
    logic is_reg;
    logic is_latch;

    assign is_reg   = (mode == OM_REG) || (mode == OM_REG2);
    assign is_latch = (mode == OM_LATCH);

    // Update the state by priority: reset, clear, preset, then clocked or latch.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (clr)              q <= 1'b0;
        else if (set)              q <= 1'b1;
        else if (is_reg && fire)   q <= ff_next(ftype, q, d_a, d_b);
        else if (is_latch && gate) q <= d_a;
    end

    // R13: a reset term always leaves the state cleared
    a_r13_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
    // R13: a lone preset always leaves the state set
    a_r13_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> q);
    // R9: without an edge the register holds
    a_r9_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg && !fire && !set && !clr) |=> $stable(q));
    // R8: a closed latch holds
    a_r8_latch_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (is_latch && !gate && !set && !clr) |=> $stable(q));

endmodule

// File: rtl/mcell_top.sv
// Module: a complete configurable macrocell. It forms the XOR-folded logic value,
// selects the clock and initialization, stores the value and applies output
// inversion after storage. The pin and feedback values are always identical.
module mcell_top
    import mcell_pkg::*;
#(
    parameter int NUM_BLK_CLK = 4,
    localparam int SEL_W = $clog2(NUM_BLK_CLK) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sop_in,
    input  logic                   xor_in,
    input  logic                   xor_en,
    input  logic [1:0]             out_mode,
    input  logic [1:0]             ff_type,
    input  logic                   inv_out,
    input  logic                   async_mode,
    input  logic [NUM_BLK_CLK-1:0] blk_clk,
    input  logic [SEL_W-1:0]       clk_sel,
    input  logic                   ptc_in,
    input  logic                   ptc_fall,
    input  logic                   blk_init_a,
    input  logic                   blk_init_b,
    input  logic                   init_swap,
    input  logic                   loc_init,
    input  logic                   loc_init_is_preset,
    output logic                   pin_out,
    output logic                   fb_out
);
    out_mode_e om;
    ff_type_e  ft;
    logic      f_val;
    logic      d_a;
    logic      gate;
    logic      fire;
    logic      set;
    logic      clr;
    logic      q;
    logic      y;

    assign om = out_mode_e'(out_mode);
    assign ft = ff_type_e'(ff_type);

    // Form the logic value; two-input flip-flop types take the terms unfolded.
    always_comb begin
        f_val = sop_in ^ (xor_en & xor_in);
        d_a   = ((ft == FT_JK) || (ft == FT_SR)) ? sop_in : f_val;
    end

    mcell_clk_sel #(.NUM_BLK_CLK(NUM_BLK_CLK)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_clk    (blk_clk),
        .clk_sel    (clk_sel),
        .async_mode (async_mode),
        .ptc_in     (ptc_in),
        .ptc_fall   (ptc_fall),
        .gate       (gate),
        .fire       (fire)
    );

    mcell_init u_init (
        .clk                (clk),
        .rst_n              (rst_n),
        .async_mode         (async_mode),
        .blk_init_a         (blk_init_a),
        .blk_init_b         (blk_init_b),
        .init_swap          (init_swap),
        .loc_init           (loc_init),
        .loc_init_is_preset (loc_init_is_preset),
        .set                (set),
        .clr                (clr)
    );

    mcell_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (om),
        .ftype (ft),
        .d_a   (d_a),
        .d_b   (xor_in),
        .gate  (gate),
        .fire  (fire),
        .set   (set),
        .clr   (clr),
        .q     (q)
    );

    // Pick the combinational or stored value, then invert after storage.
    always_comb begin
        y       = (om == OM_COMB) ? f_val : q;
        pin_out = y ^ inv_out;
        fb_out  = y ^ inv_out;
    end

endmodule

// File: tb/sim_mcell_top.sv
// Bench: a table of register-type vectors walked by one loop, then directed
// tests for reset, polarity, latch, clock selection and initialization.
module sim_mcell_top;
    localparam int CLK_P = 10;
    localparam int NBC   = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           sop_in, xor_in, xor_en, inv_out, async_mode;
    logic [1:0]     out_mode, ff_type;
    logic [NBC-1:0] blk_clk;
    logic [2:0]     clk_sel;
    logic           ptc_in, ptc_fall, blk_init_a, blk_init_b, init_swap;
    logic           loc_init, loc_init_is_preset;
    logic           pin_out, fb_out;

    int n_run  = 0;
    int n_fail = 0;

    // {ff_type[1:0], sop, xor, expected state}; registered mode, no inversion
    localparam logic [4:0] VEC [16] = '{
        {2'd0, 1'b1, 1'b0, 1'b1}, {2'd0, 1'b0, 1'b1, 1'b0},
        {2'd0, 1'b1, 1'b1, 1'b1}, {2'd1, 1'b1, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b0}, {2'd1, 1'b1, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b0, 1'b1}, {2'd2, 1'b0, 1'b1, 1'b0},
        {2'd2, 1'b1, 1'b0, 1'b1}, {2'd2, 1'b1, 1'b1, 1'b0},
        {2'd2, 1'b1, 1'b1, 1'b1}, {2'd3, 1'b0, 1'b1, 1'b0},
        {2'd3, 1'b1, 1'b0, 1'b1}, {2'd3, 1'b1, 1'b1, 1'b1},
        {2'd3, 1'b0, 1'b1, 1'b0}, {2'd3, 1'b1, 1'b1, 1'b0}
    };

    always #(CLK_P/2) clk = ~clk;

    mcell_top #(.NUM_BLK_CLK(NBC)) u0 (
        .clk(clk), .rst_n(rst_n), .sop_in(sop_in), .xor_in(xor_in),
        .xor_en(xor_en), .out_mode(out_mode), .ff_type(ff_type),
        .inv_out(inv_out), .async_mode(async_mode), .blk_clk(blk_clk),
        .clk_sel(clk_sel), .ptc_in(ptc_in), .ptc_fall(ptc_fall),
        .blk_init_a(blk_init_a), .blk_init_b(blk_init_b),
        .init_swap(init_swap), .loc_init(loc_init),
        .loc_init_is_preset(loc_init_is_preset),
        .pin_out(pin_out), .fb_out(fb_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic exp);
        n_run++;
        if (pin_out !== exp || fb_out !== exp) begin
            n_fail++;
            $display("FAIL %s: pin=%0b fb=%0b expected %0b", tag, pin_out, fb_out, exp);
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not end, got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sop_in = 0; xor_in = 0; xor_en = 0; inv_out = 0;
        async_mode = 0; out_mode = 2'd2; ff_type = 2'd0; blk_clk = '0;
        clk_sel = 3'd0; ptc_in = 0; ptc_fall = 0; blk_init_a = 0;
        blk_init_b = 0; init_swap = 0; loc_init = 0; loc_init_is_preset = 1;
        step(); step();
        chk("R1 reset state", 1'b0);
        inv_out = 1'b1; #1;
        chk("R1 R3 reset state inverted", 1'b1);
        inv_out = 1'b0;
        rst_n = 1'b1;
        step();

        // Table: one rising edge of blk_clk[0] per vector
        for (int i = 0; i < 16; i++) begin
            string tg;
            case (VEC[i][4:3])
                2'd0:    tg = "R4 D type";
                2'd1:    tg = "R5 T type";
                2'd2:    tg = "R6 JK type";
                default: tg = "R7 SR type";
            endcase
            ff_type = VEC[i][4:3]; sop_in = VEC[i][2]; xor_in = VEC[i][1];
            blk_clk[0] = 1'b1; step();
            chk(tg, VEC[i][0]);
            blk_clk[0] = 1'b0; step();
        end

        // R4 with the XOR folded in: 1^1 = 0 loaded, then 1^0 = 1
        ff_type = 2'd0; xor_en = 1; sop_in = 1; xor_in = 1;
        blk_clk[0] = 1; step(); chk("R4 D with XOR", 1'b0);
        blk_clk[0] = 0; xor_in = 0; step();
        blk_clk[0] = 1; step(); chk("R4 D with XOR", 1'b1);
        blk_clk[0] = 0; step();
        inv_out = 1; #1; chk("R3 inversion after register", 1'b0);
        inv_out = 0;

        // Combinational mode
        out_mode = 2'd0; sop_in = 1; xor_en = 1; xor_in = 1; #1;
        chk("R2 comb XOR", 1'b0);
        xor_in = 0; #1; chk("R2 comb XOR", 1'b1);
        inv_out = 1; #1; chk("R2 R3 comb inverted", 1'b0);
        inv_out = 0; xor_en = 0;

        // Latch mode; the stored state is 1 from the XOR test
        out_mode = 2'd1; sop_in = 0; blk_clk[0] = 1; step();
        chk("R8 latch open follows", 1'b0);
        sop_in = 1; step(); chk("R8 latch open follows", 1'b1);
        sop_in = 0; step(); chk("R8 latch open follows", 1'b0);
        blk_clk[0] = 0; step(); sop_in = 1; step();
        chk("R8 latch closed holds", 1'b0);

        // Clock selection in the shared scheme
        out_mode = 2'd2; ff_type = 2'd0; clk_sel = 3'd1; sop_in = 1;
        blk_clk[0] = 1; step(); chk("R9 unselected clock ignored", 1'b0);
        blk_clk[0] = 0; step();
        blk_clk[1] = 1; step(); chk("R9 selected clock edge", 1'b1);
        sop_in = 0; blk_clk[1] = 0; step();
        chk("R9 falling edge ignored", 1'b1);
        clk_sel = 3'd5; blk_clk[1] = 1; step();
        chk("R9 top select bit ignored", 1'b0);
        blk_clk[1] = 0; step();

        // Product-term clock in the individual scheme
        async_mode = 1; clk_sel = 3'd4; sop_in = 1; ptc_in = 1; step();
        chk("R10 ptc rising", 1'b1);
        ptc_in = 0; step();
        ptc_fall = 1; step(); sop_in = 0; ptc_in = 1; step();
        chk("R10 rising ignored with falling select", 1'b1);
        ptc_in = 0; step(); chk("R10 ptc falling", 1'b0);

        // Shared-scheme initialization; the state is 0 here
        async_mode = 0; clk_sel = 3'd0; ptc_fall = 0; step();
        blk_init_a = 1; step(); chk("R11 A presets", 1'b1);
        blk_init_a = 0; blk_init_b = 1; step(); chk("R11 B resets", 1'b0);
        blk_init_b = 0; init_swap = 1; blk_init_b = 1; step();
        chk("R11 swapped B presets", 1'b1);
        blk_init_b = 0; blk_init_a = 1; step(); chk("R11 swapped A resets", 1'b0);
        blk_init_a = 0; loc_init = 1; step(); chk("R11 local term ignored", 1'b0);
        loc_init = 0; blk_init_b = 1; step(); blk_init_a = 1; step();
        chk("R13 reset beats preset", 1'b0);
        blk_init_a = 0; blk_init_b = 0; init_swap = 0;
        sop_in = 1; blk_clk[0] = 1; blk_init_b = 1; step();
        chk("R13 reset beats clock edge", 1'b0);
        blk_init_b = 0; blk_init_a = 1; blk_clk[0] = 0; step();
        blk_init_a = 0; sop_in = 0; blk_clk[0] = 1; out_mode = 2'd1; blk_init_a = 1; step();
        chk("R13 preset beats open latch", 1'b1);
        blk_init_a = 0; blk_clk[0] = 0; out_mode = 2'd2; step();

        // Individual-scheme initialization; the state is 1 here
        async_mode = 1; loc_init_is_preset = 0; loc_init = 1; step();
        chk("R12 local reset", 1'b0);
        loc_init_is_preset = 1; step(); chk("R12 local preset", 1'b1);
        loc_init = 0; blk_init_b = 1; step(); chk("R12 block terms ignored", 1'b1);
        blk_init_b = 0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule